// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

A bank of hardware token latches shared by a left and a right port. Software on either side uses a token to claim a shared resource. It writes 0 to a token to ask for it and writes 1 to give it back. It then reads the token to learn who holds it: the holder reads 0 and the other side reads 1. A free token reads 1 on both sides. When the holder releases a token and the other side asked for it meanwhile, the token passes straight to the waiting side.

Each port is a plain synchronous strobe interface with no handshake. An access occurs in any cycle where the port's token select is high and its memory enable is low. With `we` high the access is a write; with `we` low and `oe` high it is a read. Every access completes in one cycle, so there is no back-pressure. Read data is registered. It reflects the token state at the start of the reading cycle and appears after the next rising edge. It then holds until the next read on that port. Only the lowest address bits pick a token, and only data bit 0 counts on a write.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free: a read of any token returns all ones on both ports, and both read registers hold all ones before any read.
- R2: Address bits 0 to 2 select one of the eight tokens. All higher address bits have no effect on reads or writes.
- R3: A write uses only data bit 0 (0 = request, 1 = release). A read returns the token value on every data bit: all zeros when the reader holds the token, all ones otherwise.
- R4: A request written to a free token makes the writer the holder. The writer then reads 0 and the other port reads 1.
- R5: A request from the non-holder does not change the visible state. A release from the non-holder does not change the visible state.
- R6: When the holder releases a token and the other port has a request pending, the other port becomes holder at once.
- R7: When the holder releases a token and no request is pending, the token becomes free.
- R8: A pending request is withdrawn when its own port writes 1 before the request is granted.
- R9: When both ports request the same free token in the same cycle, the left port becomes holder and the right port's request stays pending.
- R10: The read register captures the state from before any write made in the same cycle by either port. The read register keeps its value in cycles without a read on that port.
- R11: An access with the memory enable high is ignored, whatever the other port inputs are.
- R12: Read data appears after the first rising edge following the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left token select |
| l_mem_en | input | 1 | Left memory enable; access blocked when high |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left read enable |
| l_addr | input | ADDR_W | Left address; low 3 bits pick the token |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sel | input | 1 | Right token select |
| r_mem_en | input | 1 | Right memory enable; access blocked when high |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right read enable |
| r_addr | input | ADDR_W | Right address; low 3 bits pick the token |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
A wrong holder or a wrong pending bit stays hidden until a port reads that token. It then shows as the wrong polarity on the next cycle's read data. A lost pending bit shows only after the holder's release, when the waiting side still reads 1 instead of 0. The bench therefore reads after nearly every write in a long mixed sweep. Accesses are crowded onto a few tokens so that queued hand-overs and same-cycle ties happen often. A reference model of holder and pending state predicts every read.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_port_decode.sv
// Qualifies one port's strobes and turns them into per-token request,
// release and read controls.
module sem_port_decode #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sel,
  input  logic               mem_en,
  input  logic               we,
  input  logic               oe,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SEM-1:0] req,
  output logic [NUM_SEM-1:0] rel,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_idx
);
  logic access;
  logic dbg_unused;

  assign access     = sel & ~mem_en;
  assign rd_en      = access & ~we & oe;
  assign rd_idx     = addr[IDX_W-1:0];
  assign dbg_unused = &{1'b0, addr, wdata};

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_hit
    logic hit;
    assign hit    = (addr[IDX_W-1:0] == IDX_W'(i));
    assign req[i] = access & we & hit & ~wdata[0];
    assign rel[i] = access & we & hit &  wdata[0];
  end
endmodule

// File: rtl/sem_cell.sv
// One token: holder state plus one pending-request bit per side.
module sem_cell
  import sem_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r
);
  sem_owner_e owner, owner_n;
  logic pend_l, pend_r, pend_l_n, pend_r_n;

  always_comb begin
    owner_n  = owner;
    pend_l_n = pend_l;
    pend_r_n = pend_r;
    unique case (owner)
      SEM_FREE: begin
        pend_l_n = 1'b0;
        pend_r_n = 1'b0;
        if (req_l) begin
          owner_n  = SEM_LEFT;
          pend_r_n = req_r;
        end else if (req_r) begin
          owner_n = SEM_RIGHT;
        end
      end
      SEM_LEFT: begin
        pend_l_n = 1'b0;
        if (req_r) pend_r_n = 1'b1;
        if (rel_r) pend_r_n = 1'b0;
        if (rel_l) begin
          if (pend_r_n) begin
            owner_n  = SEM_RIGHT;
            pend_r_n = 1'b0;
          end else begin
            owner_n = SEM_FREE;
          end
        end
      end
      SEM_RIGHT: begin
        pend_r_n = 1'b0;
        if (req_l) pend_l_n = 1'b1;
        if (rel_l) pend_l_n = 1'b0;
        if (rel_r) begin
          if (pend_l_n) begin
            owner_n  = SEM_LEFT;
            pend_l_n = 1'b0;
          end else begin
            owner_n = SEM_FREE;
          end
        end
      end
      default: begin
        owner_n  = SEM_FREE;
        pend_l_n = 1'b0;
        pend_r_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner  <= SEM_FREE;
      pend_l <= 1'b0;
      pend_r <= 1'b0;
    end else begin
      owner  <= owner_n;
      pend_l <= pend_l_n;
      pend_r <= pend_r_n;
    end
  end

  assign own_l = (owner == SEM_LEFT);
  assign own_r = (owner == SEM_RIGHT);

  // R5
  left_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == SEM_LEFT && !rel_l) |=> owner == SEM_LEFT);
  // R5
  right_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == SEM_RIGHT && !rel_r) |=> owner == SEM_RIGHT);
  // R6
  handoff_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == SEM_LEFT && pend_r && rel_l && !rel_r) |=> owner == SEM_RIGHT);
  // R9
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == SEM_FREE && req_l) |=> owner == SEM_LEFT);
  // R7
  holder_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((owner == SEM_LEFT && pend_l) || (owner == SEM_RIGHT && pend_r)));
endmodule

// File: rtl/sem_read_reg.sv
// Registered read path for one port.
module sem_read_reg #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [NUM_SEM-1:0] own,
  output logic [DATA_W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '1;
    else if (rd_en) rdata <= {DATA_W{~own[rd_idx]}};
  end

  // R3
  uniform_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0) || (rdata == '1));
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_SEM);

  logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r, own_l, own_r;
  logic               rd_l, rd_r;
  logic [IDX_W-1:0]   idx_l, idx_r;

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .sel(l_sel), .mem_en(l_mem_en), .we(l_we), .oe(l_oe), .addr(l_addr),
    .wdata(l_wdata), .req(req_l), .rel(rel_l), .rd_en(rd_l), .rd_idx(idx_l));

  sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .sel(r_sel), .mem_en(r_mem_en), .we(r_we), .oe(r_oe), .addr(r_addr),
    .wdata(r_wdata), .req(req_r), .rel(rel_r), .rd_en(rd_r), .rd_idx(idx_r));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(req_l[i]), .rel_l(rel_l[i]),
      .req_r(req_r[i]), .rel_r(rel_r[i]),
      .own_l(own_l[i]), .own_r(own_r[i]));
  end

  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_l), .rd_idx(idx_l), .own(own_l),
    .rdata(l_rdata));

  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_r), .rd_idx(idx_r), .own(own_r),
    .rdata(r_rdata));

  // R4
  single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);
  // R11
  blocked_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_mem_en || !l_sel) |-> (req_l == '0 && rel_l == '0));
endmodule

// File: tb/sem_bank_tb_top.sv
module sem_bank_tb_top;
  localparam int NS = 8;
  localparam int AW = 15;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_mem_en = 0, l_we = 0, l_oe = 0;
  logic r_sel = 0, r_mem_en = 0, r_we = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_own [NS];      // 0 free, 1 left, 2 right
  bit m_pl [NS];
  bit m_pr [NS];
  logic [DW-1:0] exp_l = '1, exp_r = '1;

  always #4 clk = ~clk;

  sem_bank #(.NUM_SEM(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_we(l_we), .l_oe(l_oe),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_we(r_we), .r_oe(r_oe),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_mem_en = 0; l_we = 0; l_oe = 0;
    r_sel = 0; r_mem_en = 0; r_we = 0; r_oe = 0;
  endtask

  // Inputs are already set; advance one edge, predict and compare.
  task automatic run_cycle(input string tag);
    bit al, ar, wl0, wl1, wr0, wr1;
    int il, ir;
    al = l_sel && !l_mem_en; ar = r_sel && !r_mem_en;
    il = int'(l_addr[2:0]); ir = int'(r_addr[2:0]);
    if (al && !l_we && l_oe) exp_l = (m_own[il] == 1) ? '0 : '1;
    if (ar && !r_we && r_oe) exp_r = (m_own[ir] == 2) ? '0 : '1;
    for (int s = 0; s < NS; s++) begin
      wl0 = al && l_we && il == s && !l_wdata[0];
      wl1 = al && l_we && il == s &&  l_wdata[0];
      wr0 = ar && r_we && ir == s && !r_wdata[0];
      wr1 = ar && r_we && ir == s &&  r_wdata[0];
      if (m_own[s] == 0) begin
        if (wl0) begin m_own[s] = 1; m_pr[s] = wr0; end
        else if (wr0) m_own[s] = 2;
      end else if (m_own[s] == 1) begin
        if (wr0) m_pr[s] = 1;
        if (wr1) m_pr[s] = 0;
        if (wl1) begin
          m_own[s] = m_pr[s] ? 2 : 0;
          m_pr[s] = 0;
        end
      end else begin
        if (wl0) m_pl[s] = 1;
        if (wl1) m_pl[s] = 0;
        if (wr1) begin
          m_own[s] = m_pl[s] ? 1 : 0;
          m_pl[s] = 0;
        end
      end
    end
    @(posedge clk);
    #1;
    check({tag, " left"}, l_rdata, exp_l);
    check({tag, " right"}, r_rdata, exp_r);
  endtask

  task automatic lw(input int s, input bit v, input logic [AW-1:0] hi = '0);
    l_sel = 1; l_we = 1; l_oe = 0; l_addr = (hi << 3) | AW'(s); l_wdata = {7'h55, v};
  endtask
  task automatic rw(input int s, input bit v, input logic [AW-1:0] hi = '0);
    r_sel = 1; r_we = 1; r_oe = 0; r_addr = (hi << 3) | AW'(s); r_wdata = {7'h2A, v};
  endtask
  task automatic lr(input int s, input logic [AW-1:0] hi = '0);
    l_sel = 1; l_we = 0; l_oe = 1; l_addr = (hi << 3) | AW'(s);
  endtask
  task automatic rr(input int s, input logic [AW-1:0] hi = '0);
    r_sel = 1; r_we = 0; r_oe = 1; r_addr = (hi << 3) | AW'(s);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int s = 0; s < NS; s++) begin m_own[s] = 0; m_pl[s] = 0; m_pr[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 reset left", l_rdata, '1);
    check("R1 reset right", r_rdata, '1);
    for (int s = 0; s < NS; s++) begin
      idle(); lr(s); rr(s); run_cycle("R1 free after reset");
    end
    // R2 R4: request with high bits set, read with other high bits
    idle(); lw(2, 0, 15'h0ABC); run_cycle("R4 request");
    idle(); lr(2, 15'h0123); rr(2, 15'h0FFF); run_cycle("R2 R4 holder reads 0");
    // R5: non-holder request queues, no visible change
    idle(); rw(2, 0); run_cycle("R5 queued");
    idle(); lr(2); rr(2); run_cycle("R5 unchanged");
    // R12 latency: read then idle keeps result
    idle(); run_cycle("R12 hold");
    // R10: right reads while left hands over in same cycle
    idle(); lw(2, 1); rr(2); run_cycle("R10 pre-write capture");
    idle(); lr(2); rr(2); run_cycle("R6 handed over");
    // R7: release with nothing pending
    idle(); rw(2, 1); run_cycle("R7 release");
    idle(); lr(2); rr(2); run_cycle("R7 free");
    // R8: pending withdrawn
    idle(); rw(4, 0); run_cycle("R8 right holds");
    idle(); lw(4, 0); run_cycle("R8 left pending");
    idle(); lw(4, 1); run_cycle("R8 left withdraws");
    idle(); rw(4, 1); run_cycle("R8 right releases");
    idle(); lr(4); rr(4); run_cycle("R8 free after withdraw");
    // R9: tie
    idle(); lw(5, 0); rw(5, 0); run_cycle("R9 tie");
    idle(); lr(5); rr(5); run_cycle("R9 left wins");
    idle(); lw(5, 1); run_cycle("R9 release");
    idle(); lr(5); rr(5); run_cycle("R9 right promoted");
    // R3: only bit 0 written, all bits read
    idle(); rw(3, 0); r_wdata = 8'hFE; run_cycle("R3 write FE");
    idle(); rr(3); run_cycle("R3 reads all zero");
    idle(); rw(3, 1); r_wdata = 8'h01; run_cycle("R3 write 01");
    idle(); rr(3); lr(3); run_cycle("R3 reads all one");
    // R11: memory enable blocks access
    idle(); lw(7, 0); l_mem_en = 1; run_cycle("R11 blocked write");
    idle(); lr(7); rr(7); run_cycle("R11 still free");
    idle(); lr(7); l_mem_en = 1; rw(7, 0); run_cycle("R11 blocked read");
    idle(); lr(7); run_cycle("R11 left reads 1");
    idle(); rw(7, 1); run_cycle("R11 cleanup");
    // Mixed sweep over two crowded tokens plus the rest
    lf = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      idle();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      l_sel = lf[0] | lf[1]; l_mem_en = (lf[4:2] == 3'd0);
      l_we = lf[5]; l_oe = lf[6] | ~lf[5];
      l_addr = {lf[15:4], (lf[7] ? 3'(lf[8]) : lf[10:8])};
      l_wdata = {lf[14:8], lf[9]};
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r_sel = lf[0] | lf[1]; r_mem_en = (lf[4:2] == 3'd0);
      r_we = lf[5]; r_oe = lf[6] | ~lf[5];
      r_addr = {lf[15:4], (lf[7] ? 3'(lf[8]) : lf[10:8])};
      r_wdata = {lf[14:8], lf[9]};
      run_cycle("R5 R6 R7 R8 R9 R10 sweep");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule